// File: doc/BRIEF.md
# Chip-Select Idle Release Timer

This block decides when the chip select of an external serial memory is let go. When the controller runs in its memory-mapped mode, it is useful to keep the device selected between accesses. A burst of nearby reads can then reuse the open selection. Holding it forever wastes power and blocks other traffic, however. The block therefore counts consecutive clock cycles in which no access is running. When that count reaches a programmed 16-bit limit, it drops the chip select and raises a sticky timeout flag. The flag can drive an interrupt when the interrupt is enabled.

In the other three operating modes, the chip select is released as soon as the access ends, and no timeout is ever reported. A select bit, captured at the start of each access, picks which of the two active-low chip-select lines is driven. The block that produces the accesses feeds in a one-cycle start pulse and a busy level.

Top module: `cs_idle_timeout`

## Requirements
- R1: After reset both chip-select outputs are high, and the timeout flag and the interrupt are low.
- R2: A high `acc_start_i` at a clock edge makes the selected chip select low from that edge on, including when the line had been released. `cs_sel_i` = 0 drives `cs0_n_o` low and 1 drives `cs1_n_o` low. The other line stays high, and at most one line is ever low.
- R3: In mode 3 with `tmo_en_i` = 1, the chip select is released at the L-th consecutive idle clock edge, where L is `tmo_limit_i` and a limit of 0 acts as 1. It is still held after L-1 idle edges. An idle edge is one where the chip select is held, `busy_i` is low and `acc_start_i` is low.
- R4: In mode 3 with `tmo_en_i` = 0, the chip select remains low for as long as no other event releases it, whatever the idle time.
- R5: In modes 0, 1 and 2, the chip select is released at the first idle edge, and the timeout flag is not set.
- R6: Any edge with `busy_i` or `acc_start_i` high restarts the idle count from zero.
- R7: The timeout flag is set at the edge that releases the chip select through the timeout. It stays set until an edge with `tmo_clr_i` high. A set and a clear at the same edge leave it set.
- R8: `tmo_irq_o` is high exactly when the timeout flag is high and `tmo_irq_en_i` is high.
- R9: Leaving mode 3 while the chip select is held and idle releases it at the next edge, without setting the flag.
- R10: A change of `cs_sel_i` while the chip select is held between accesses does not move the selection. The new value takes effect only at the next access start.

Mode encoding on `mode_i`: 0 indirect write, 1 indirect read, 2 status polling, 3 memory-mapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Operating mode, 3 = memory-mapped |
| tmo_en_i | input | 1 | Enables the idle timeout in mode 3 |
| tmo_limit_i | input | 16 | Idle cycles before release |
| cs_sel_i | input | 1 | Chip-select line choice, sampled at access start |
| busy_i | input | 1 | An access is in progress |
| acc_start_i | input | 1 | One-cycle pulse at the start of an access |
| tmo_irq_en_i | input | 1 | Timeout interrupt enable |
| tmo_clr_i | input | 1 | Write-one-to-clear for the timeout flag |
| cs0_n_o | output | 1 | First chip select, active low |
| cs1_n_o | output | 1 | Second chip select, active low |
| tmo_flag_o | output | 1 | Sticky timeout flag |
| tmo_irq_o | output | 1 | Timeout interrupt |

## Verification
The bench samples the chip select one edge before and exactly at the expected release. A counter that is off by one, or that mishandles a zero limit or the full 16-bit limit, is caught at that boundary. An access restarted part way through the idle window must push the release out by a full limit; a design that kept counting would release early. The bench also changes the line select while the chip select is held, clears the flag on the same edge that sets it, and leaves memory-mapped mode during a hold. A design that switched lines mid-hold, let the clear win, or raised a timeout on a mode change would show a wrong line, a missing flag or a spurious flag.

// File: rtl/cs_tmo_pkg.sv
package cs_tmo_pkg;

    localparam int TMO_W  = 16;
    localparam int NUM_CS = 2;
    localparam int SEL_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

    typedef enum logic [1:0] {
        MODE_WRITE = 2'd0,
        MODE_READ  = 2'd1,
        MODE_POLL  = 2'd2,
        MODE_MAP   = 2'd3
    } op_mode_e;

endpackage

// File: rtl/cs_idle_counter.sv
module cs_idle_counter #(
    parameter int TMO_W = cs_tmo_pkg::TMO_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [TMO_W-1:0] limit_i,
    output logic             expire_o
);
    localparam int CNT_W = TMO_W + 1;

    typedef struct packed {
        logic [TMO_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t          st_d, st_q;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        st_d     = st_q;
        cnt_inc  = {1'b0, st_q.cnt} + CNT_W'(1);
        // extra bit keeps the compare exact at the full-scale limit
        expire_o = run_i && (cnt_inc >= {1'b0, limit_i});
        if (!run_i || expire_o) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = cnt_inc[TMO_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/cs_select_ctrl.sv
module cs_select_ctrl #(
    parameter int NUM_CS = cs_tmo_pkg::NUM_CS,
    parameter int SEL_W  = cs_tmo_pkg::SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              busy_i,
    input  logic              map_mode_i,
    input  logic              expire_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic              active_o,
    output logic [NUM_CS-1:0] cs_n_o
);
    typedef struct packed {
        logic             active;
        logic [SEL_W-1:0] sel;
    } sel_st_t;

    sel_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.active = 1'b1;
            st_d.sel    = sel_i;
        end else if (expire_i) begin
            st_d.active = 1'b0;
        end else if (!map_mode_i && !busy_i) begin
            st_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.active;

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs_line
        assign cs_n_o[g] = ~(st_q.active && (st_q.sel == SEL_W'(g)));
    end

endmodule

// File: rtl/cs_tmo_flag.sv
module cs_tmo_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic irq_en_i,
    output logic flag_o,
    output logic irq_o
);
    typedef struct packed {
        logic flag;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_i) begin
            st_d.flag = 1'b1;
        end else if (clr_i) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;
    assign irq_o  = st_q.flag & irq_en_i;

endmodule

// File: rtl/cs_idle_timeout.sv
module cs_idle_timeout
    import cs_tmo_pkg::*;
#(
    parameter int LIMIT_W = TMO_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         mode_i,
    input  logic               tmo_en_i,
    input  logic [LIMIT_W-1:0] tmo_limit_i,
    input  logic               cs_sel_i,
    input  logic               busy_i,
    input  logic               acc_start_i,
    input  logic               tmo_irq_en_i,
    input  logic               tmo_clr_i,
    output logic               cs0_n_o,
    output logic               cs1_n_o,
    output logic               tmo_flag_o,
    output logic               tmo_irq_o
);
    logic              map_mode;
    logic              cs_active;
    logic              idle_run;
    logic              expire;
    logic [NUM_CS-1:0] cs_n;

    assign map_mode = (op_mode_e'(mode_i) == MODE_MAP);
    assign idle_run = cs_active && map_mode && tmo_en_i && !busy_i && !acc_start_i;

    cs_idle_counter #(.TMO_W(LIMIT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (idle_run),
        .limit_i  (tmo_limit_i),
        .expire_o (expire)
    );

    cs_select_ctrl #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (acc_start_i),
        .busy_i     (busy_i),
        .map_mode_i (map_mode),
        .expire_i   (expire),
        .sel_i      (SEL_W'(cs_sel_i)),
        .active_o   (cs_active),
        .cs_n_o     (cs_n)
    );

    cs_tmo_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (expire),
        .clr_i    (tmo_clr_i),
        .irq_en_i (tmo_irq_en_i),
        .flag_o   (tmo_flag_o),
        .irq_o    (tmo_irq_o)
    );

    assign cs0_n_o = cs_n[0];
    assign cs1_n_o = cs_n[1];

endmodule

// File: rtl/cs_idle_timeout_chk.sv
module cs_idle_timeout_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_i,
    input logic       tmo_en_i,
    input logic       acc_start_i,
    input logic       tmo_irq_en_i,
    input logic       tmo_clr_i,
    input logic       cs0_n_o,
    input logic       cs1_n_o,
    input logic       tmo_flag_o,
    input logic       tmo_irq_o
);
    logic held;
    assign held = !(cs0_n_o && cs1_n_o);

    AST_CS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~cs1_n_o, ~cs0_n_o}) <= 1); // R2
    AST_START_SELECTS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_start_i |=> held); // R2
    AST_HOLD_NO_TMO: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd3 && !tmo_en_i && held) |=> held); // R4
    AST_FLAG_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_flag_o) |-> (!held && $past(mode_i == 2'd3 && tmo_en_i))); // R3
    AST_NONMAP_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != 2'd3) |=> !$rose(tmo_flag_o)); // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_flag_o && !tmo_clr_i) |=> tmo_flag_o); // R7
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !tmo_irq_en_i |-> !tmo_irq_o); // R8

endmodule

bind cs_idle_timeout cs_idle_timeout_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_i       (mode_i),
    .tmo_en_i     (tmo_en_i),
    .acc_start_i  (acc_start_i),
    .tmo_irq_en_i (tmo_irq_en_i),
    .tmo_clr_i    (tmo_clr_i),
    .cs0_n_o      (cs0_n_o),
    .cs1_n_o      (cs1_n_o),
    .tmo_flag_o   (tmo_flag_o),
    .tmo_irq_o    (tmo_irq_o)
);

// File: tb/cs_idle_timeout_tb.sv
`timescale 1ns/1ps
module cs_idle_timeout_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_i = 2'd0;
    logic        tmo_en_i = 1'b0;
    logic [15:0] tmo_limit_i = 16'd0;
    logic        cs_sel_i = 1'b0;
    logic        busy_i = 1'b0;
    logic        acc_start_i = 1'b0;
    logic        tmo_irq_en_i = 1'b0;
    logic        tmo_clr_i = 1'b0;
    logic        cs0_n_o, cs1_n_o, tmo_flag_o, tmo_irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    cs_idle_timeout u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_i       (mode_i),
        .tmo_en_i     (tmo_en_i),
        .tmo_limit_i  (tmo_limit_i),
        .cs_sel_i     (cs_sel_i),
        .busy_i       (busy_i),
        .acc_start_i  (acc_start_i),
        .tmo_irq_en_i (tmo_irq_en_i),
        .tmo_clr_i    (tmo_clr_i),
        .cs0_n_o      (cs0_n_o),
        .cs1_n_o      (cs1_n_o),
        .tmo_flag_o   (tmo_flag_o),
        .tmo_irq_o    (tmo_irq_o)
    );

    // {mode[1:0], enable, select, irq enable, limit[15:0]}
    localparam logic [20:0] VECS [9] = '{
        {2'd3, 1'b1, 1'b0, 1'b1, 16'd5},
        {2'd3, 1'b1, 1'b1, 1'b0, 16'd1},
        {2'd3, 1'b1, 1'b1, 1'b1, 16'd0},
        {2'd3, 1'b0, 1'b0, 1'b1, 16'd3},
        {2'd0, 1'b1, 1'b1, 1'b1, 16'd4},
        {2'd2, 1'b1, 1'b0, 1'b1, 16'd7},
        {2'd3, 1'b1, 1'b0, 1'b0, 16'd300},
        {2'd1, 1'b0, 1'b1, 1'b1, 16'd2},
        {2'd3, 1'b1, 1'b1, 1'b1, 16'hFFFF}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] low_for(input logic sel);
        return sel ? 2'b01 : 2'b10;   // {cs1_n, cs0_n}
    endfunction

    task automatic begin_access(input logic sel);
        @(negedge clk);
        cs_sel_i = sel; acc_start_i = 1'b1; busy_i = 1'b1;
        @(negedge clk);
        acc_start_i = 1'b0;
        check("R2", "cs after start", {cs1_n_o, cs0_n_o}, low_for(sel));
        @(negedge clk);
        @(negedge clk);
        busy_i = 1'b0;
    endtask

    task automatic tidy();
        @(negedge clk);
        mode_i = 2'd0; tmo_clr_i = 1'b1;
        @(negedge clk);
        tmo_clr_i = 1'b0;
    endtask

    task automatic run_vec(input logic [20:0] v);
        logic        map, en, sel, ien;
        logic [15:0] lim;
        int          rel;
        string       rq;
        map = (v[20:19] == 2'd3); en = v[18]; sel = v[17]; ien = v[16]; lim = v[15:0];
        rel = map ? (en ? ((lim == 0) ? 1 : int'(lim)) : 0) : 1;
        rq  = map ? "R3" : "R5";
        @(negedge clk);
        mode_i = v[20:19]; tmo_en_i = en; tmo_irq_en_i = ien; tmo_limit_i = lim;
        begin_access(sel);
        if (rel == 0) begin
            repeat (40) @(negedge clk);
            check("R4", "cs held", {cs1_n_o, cs0_n_o}, low_for(sel));
            check("R4", "no flag", tmo_flag_o, 1'b0);
            tidy();
            check("R9", "release on mode exit", {cs1_n_o, cs0_n_o}, 2'b11);
            check("R9", "no flag on mode exit", tmo_flag_o, 1'b0);
        end else begin
            if (rel > 1) begin
                repeat (rel - 1) @(negedge clk);
                check(rq, "held one edge early", {cs1_n_o, cs0_n_o}, low_for(sel));
            end
            @(negedge clk);
            check(rq, "released", {cs1_n_o, cs0_n_o}, 2'b11);
            check(map ? "R7" : "R5", "flag at release", tmo_flag_o, map);
            check("R8", "irq", tmo_irq_o, map & ien);
            if (map) begin
                repeat (3) @(negedge clk);
                check("R7", "flag sticky", tmo_flag_o, 1'b1);
            end
            tidy();
            check("R7", "flag cleared", tmo_flag_o, 1'b0);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "cs in reset", {cs1_n_o, cs0_n_o}, 2'b11);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "cs after reset", {cs1_n_o, cs0_n_o}, 2'b11);
        check("R1", "flag after reset", tmo_flag_o, 1'b0);
        check("R1", "irq after reset", tmo_irq_o, 1'b0);

        for (int i = 0; i < 9; i++) run_vec(VECS[i]);

        // R6: a new access midway restarts the idle window
        @(negedge clk);
        mode_i = 2'd3; tmo_en_i = 1'b1; tmo_limit_i = 16'd10; tmo_irq_en_i = 1'b1;
        begin_access(1'b0);
        repeat (6) @(negedge clk);
        acc_start_i = 1'b1; busy_i = 1'b1;
        @(negedge clk);
        acc_start_i = 1'b0; busy_i = 1'b0;
        repeat (9) @(negedge clk);
        check("R6", "held after restart", {cs1_n_o, cs0_n_o}, 2'b10);
        @(negedge clk);
        check("R6", "released full window", {cs1_n_o, cs0_n_o}, 2'b11);

        // R2: reassert after release on the other line, R10: select frozen while held
        acc_start_i = 1'b1; busy_i = 1'b1; cs_sel_i = 1'b1;
        @(negedge clk);
        acc_start_i = 1'b0; busy_i = 1'b0; tmo_en_i = 1'b0;
        check("R2", "reassert after release", {cs1_n_o, cs0_n_o}, 2'b01);
        cs_sel_i = 1'b0;
        repeat (5) @(negedge clk);
        check("R10", "select frozen while held", {cs1_n_o, cs0_n_o}, 2'b01);
        tidy();

        // R7: set and clear on the same edge
        @(negedge clk);
        mode_i = 2'd3; tmo_en_i = 1'b1; tmo_limit_i = 16'd3; tmo_irq_en_i = 1'b1;
        begin_access(1'b0);
        repeat (2) @(negedge clk);
        tmo_clr_i = 1'b1;
        @(negedge clk);
        tmo_clr_i = 1'b0;
        check("R7", "set wins over clear", tmo_flag_o, 1'b1);
        check("R8", "irq with enable", tmo_irq_o, 1'b1);
        tmo_irq_en_i = 1'b0;
        #1;
        check("R8", "irq masked", tmo_irq_o, 1'b0);
        tidy();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule